// File: doc/BRIEF.md
# Dual-Mode Stack Pointer Unit

This block holds the 16-bit stack pointer of an 8-bit processor core. The pointer works in one of two modes. In page mode only the low byte moves, and the high byte names the stack page. In word mode all sixteen bits form the pointer. The mode decides how every increment, decrement and offset addition wraps. Push and pull strobes update the pointer and the block returns the address for each stack access. Two transfer strobes move the high byte to and from the Y register, and each of them also sets the mode.

The block also generates addresses for the stack-relative indirect indexed mode. A start strobe carries an 8-bit displacement. The block then reads a two-byte pointer, low byte first, from a byte-wide memory read port at the stack pointer plus the displacement. It adds Y to that pointer and gives the 16-bit effective address together with a one-cycle done strobe.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer reads 0x01FF, the unit is in page mode (`word_mode_o` = 0), and `busy_o` and `done_o` are low.
- R2: On a push, `stk_addr_o` equals the current pointer and the pointer then drops by one. On a pull, `stk_addr_o` equals the pointer plus one, and the pointer takes that value. In word mode both steps carry across all 16 bits.
- R3: In page mode a push or pull wraps the low byte between 0x00 and 0xFF, and the high byte does not change.
- R4: The high-to-Y transfer raises `y_wr_o` in the same cycle with `y_wdata_o` equal to the current high byte, and page mode applies from the next cycle.
- R5: The Y-to-high transfer loads `y_i` into the high byte and selects word mode (`word_mode_o` = 1). If a transfer is requested, a push or pull in the same cycle is ignored. If both transfers are requested, the Y-to-high transfer wins.
- R6: When the unit is idle, a start is accepted. One cycle later `mem_rd_o` is high with the pointer low-byte address, which is the pointer plus the zero-extended displacement. The next cycle reads the following address. Read data arrives one cycle after each request.
- R7: In page mode both pointer-byte addresses stay in the stack page. With pointer 0x01FF and displacement 0, the reads go to 0x01FF and then 0x0100.
- R8: In word mode the pointer-byte addresses carry into the high byte. With pointer 0x01FF and displacement 0, the reads go to 0x01FF and then 0x0200.
- R9: `done_o` pulses for one cycle, four cycles after the accepted start. That is one cycle after the high pointer byte returns. In that cycle `ea_o` equals the fetched pointer plus the zero-extended Y captured at start, modulo 2^16.
- R10: A start that arrives while a sequence is in progress is ignored and does not change the addresses or the result of that sequence.
- R11: A push and a pull in the same cycle leave the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push strobe |
| pull_i | input | 1 | Pull strobe |
| tsy_i | input | 1 | Copy the high byte to Y and select page mode |
| tys_i | input | 1 | Load the high byte from Y and select word mode |
| y_i | input | 8 | Current Y register value |
| stk_addr_o | output | 16 | Address of this cycle's push or pull access |
| sp_o | output | 16 | Current stack pointer |
| word_mode_o | output | 1 | 1 = word mode, 0 = page mode |
| y_wr_o | output | 1 | Write strobe for Y |
| y_wdata_o | output | 8 | Value to write into Y |
| ind_start_i | input | 1 | Start a stack-indirect indexed sequence |
| disp_i | input | 8 | Displacement for that sequence |
| mem_rd_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory read address |
| mem_rdata_i | input | 8 | Read data, valid one cycle after the request |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Effective address valid this cycle |
| ea_o | output | 16 | Effective address |

## Verification
Pushes and pulls are run in both modes, at the low-byte boundary and across the 0x0200/0x0300 high-byte boundaries. These runs separate a page-confined wrap from a full 16-bit carry. Indirect sequences start from pointer 0x01FF in each mode, which tells page wrap apart from carry on the second read. A displacement of 0xF0 checks zero extension against sign extension, and a pointer of 0xFFFF plus Y checks wrap of the effective address. A second start during a sequence, simultaneous push and pull, and a push alongside a transfer show that the ignored strobes leave every output as the model predicts.

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_i,
  input  logic            pull_i,
  input  logic            tsy_i,
  input  logic            tys_i,
  input  logic [DW-1:0]   y_i,
  output logic [2*DW-1:0] stk_addr_o,
  output logic [2*DW-1:0] sp_o,
  output logic            word_mode_o,
  output logic            y_wr_o,
  output logic [DW-1:0]   y_wdata_o,
  input  logic            ind_start_i,
  input  logic [DW-1:0]   disp_i,
  output logic            mem_rd_o,
  output logic [2*DW-1:0] mem_addr_o,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [2*DW-1:0] ea_o
);
  localparam int AW = 2 * DW;

  typedef enum logic [2:0] {S_IDLE, S_LO, S_HI, S_FIN, S_DONE} st_t;

  logic [DW-1:0] sph, spl;
  logic          wmode;
  logic [AW-1:0] sp, sp_inc, sp_dec, base_nxt, ptr_hi_addr;
  logic          xfer, step_dn, step_up;

  st_t           st;
  logic [AW-1:0] base, ea;
  logic          bmode;
  logic [DW-1:0] ylat, lo;

  assign sp     = {sph, spl};
  assign sp_inc = wmode ? sp + 1'b1 : {sph, spl + 1'b1};
  assign sp_dec = wmode ? sp - 1'b1 : {sph, spl - 1'b1};

  assign xfer    = tys_i | tsy_i;
  assign step_dn = push_i & ~pull_i & ~xfer;
  assign step_up = pull_i & ~push_i & ~xfer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sph   <= DW'(1);
      spl   <= '1;
      wmode <= 1'b0;
    end else if (tys_i) begin
      sph   <= y_i;
      wmode <= 1'b1;
    end else if (tsy_i) begin
      wmode <= 1'b0;
    end else if (step_dn) begin
      {sph, spl} <= sp_dec;
    end else if (step_up) begin
      {sph, spl} <= sp_inc;
    end
  end

  assign sp_o        = sp;
  assign word_mode_o = wmode;
  assign stk_addr_o  = pull_i ? sp_inc : sp;
  assign y_wr_o      = tsy_i & ~tys_i;
  assign y_wdata_o   = sph;

  assign base_nxt    = wmode ? sp + {{DW{1'b0}}, disp_i} : {sph, spl + disp_i};
  assign ptr_hi_addr = bmode ? base + 1'b1 : {base[AW-1:DW], base[DW-1:0] + 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      base  <= '0;
      bmode <= 1'b0;
      ylat  <= '0;
      lo    <= '0;
      ea    <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (ind_start_i) begin
          base  <= base_nxt;
          bmode <= wmode;
          ylat  <= y_i;
          st    <= S_LO;
        end
        S_LO:   st <= S_HI;
        S_HI: begin
          lo <= mem_rdata_i;
          st <= S_FIN;
        end
        S_FIN: begin
          ea <= {mem_rdata_i, lo} + {{DW{1'b0}}, ylat};
          st <= S_DONE;
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_rd_o   = (st == S_LO) | (st == S_HI);
  assign mem_addr_o = (st == S_HI) ? ptr_hi_addr : base;
  assign busy_o     = st != S_IDLE;
  assign done_o     = st == S_DONE;
  assign ea_o       = ea;

  AST_TYS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    tys_i |=> (word_mode_o && sp_o[AW-1:DW] == $past(y_i))); // R5
  AST_TSY_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (tsy_i && !tys_i) |=> !word_mode_o); // R4
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_mode_o && !tys_i && (push_i || pull_i)) |=> $stable(sp_o[AW-1:DW])); // R3
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pull_i && !xfer) |=> $stable(sp_o)); // R11
  AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HI && !bmode) |-> mem_addr_o[AW-1:DW] == $past(mem_addr_o[AW-1:DW])); // R7
  AST_WORD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HI && bmode) |-> mem_addr_o == AW'($past(mem_addr_o) + 1'b1)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o); // R10
endmodule

// File: tb/tb_stack_ptr_unit.sv
`timescale 1ns/1ps
module tb_stack_ptr_unit;
  logic        clk = 0, rst_n = 0;
  logic        push = 0, pull = 0, tsy = 0, tys = 0, start = 0;
  logic [7:0]  y = 0, disp = 0, rdata = 0;
  logic [15:0] stk_addr, sp, maddr, ea;
  logic        wm, ywr, mrd, busy, done;
  logic [7:0]  ywd;

  int n_run = 0, n_fail = 0, cyc = 0;

  stack_ptr_unit dut (
    .clk(clk), .rst_n(rst_n), .push_i(push), .pull_i(pull), .tsy_i(tsy), .tys_i(tys),
    .y_i(y), .stk_addr_o(stk_addr), .sp_o(sp), .word_mode_o(wm), .y_wr_o(ywr),
    .y_wdata_o(ywd), .ind_start_i(start), .disp_i(disp), .mem_rd_o(mrd),
    .mem_addr_o(maddr), .mem_rdata_i(rdata), .busy_o(busy), .done_o(done), .ea_o(ea));

  always #2.5 clk = ~clk;

  function automatic int memf(int a);
    if (a == 16'h0300 || a == 16'h0301) return 8'hFF;
    return ((a * 37 + 11) ^ (a >> 8)) & 8'hFF;
  endfunction

  always @(posedge clk) if (mrd) rdata <= 8'(memf(int'(maddr)));

  // reference model
  int m_sp = 16'h01FF, m_wm = 0, m_st = 0, m_base = 0, m_bw = 0, m_y = 0, m_ea = 0;

  function automatic int nxt_addr(int b, int w);
    return w ? ((b + 1) & 16'hFFFF) : ((b & 16'hFF00) | ((b + 1) & 8'hFF));
  endfunction
  function automatic int sp_step(int s, int w, int d);
    return w ? ((s + d) & 16'hFFFF) : ((s & 16'hFF00) | ((s + d) & 8'hFF));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sp = 16'h01FF; m_wm = 0; m_st = 0;
    end else begin
      case (m_st)
        0: if (start) begin
             m_base = m_wm ? ((m_sp + int'(disp)) & 16'hFFFF)
                           : ((m_sp & 16'hFF00) | ((m_sp + int'(disp)) & 8'hFF));
             m_bw = m_wm; m_y = int'(y); m_st = 1;
           end
        1: m_st = 2;
        2: m_st = 3;
        3: begin
             m_ea = (memf(m_base) | (memf(nxt_addr(m_base, m_bw)) << 8)) + m_y;
             m_ea = m_ea & 16'hFFFF; m_st = 4;
           end
        default: m_st = 0;
      endcase
      if (tys) begin m_sp = (int'(y) << 8) | (m_sp & 8'hFF); m_wm = 1; end
      else if (tsy) m_wm = 0;
      else if (push && !pull) m_sp = sp_step(m_sp, m_wm, -1);
      else if (pull && !push) m_sp = sp_step(m_sp, m_wm, 1);
    end
  end

  task automatic chk(string tag, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R2 sp", int'(sp), m_sp);
    chk("R5 mode", int'(wm), m_wm);
    chk("R10 busy", int'(busy), int'(m_st != 0));
    chk("R9 done", int'(done), int'(m_st == 4));
    chk("R6 rd", int'(mrd), int'(m_st == 1 || m_st == 2));
    if (m_st == 1) chk("R6 addr_lo", int'(maddr), m_base);
    if (m_st == 2) chk("R7 R8 addr_hi", int'(maddr), nxt_addr(m_base, m_bw));
    if (m_st == 4) chk("R9 ea", int'(ea), m_ea);
    if ((push ^ pull) && !tsy && !tys)
      chk("R2 stk_addr", int'(stk_addr), pull ? sp_step(m_sp, m_wm, 1) : m_sp);
    chk("R4 ywr", int'(ywr), int'(tsy && !tys));
    if (tsy) chk("R4 ywdata", int'(ywd), m_sp >> 8);
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic do_push(); push = 1; tick(); push = 0; endtask
  task automatic do_pull(); pull = 1; tick(); pull = 0; endtask
  task automatic do_tsy(); tsy = 1; tick(); tsy = 0; endtask
  task automatic do_tys(logic [7:0] v); y = v; tys = 1; tick(); tys = 0; endtask
  task automatic ind(logic [7:0] d, logic [7:0] yy);
    disp = d; y = yy; start = 1; tick(); start = 0;
    for (int i = 0; i < 5; i++) tick();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 reset sp", int'(sp), 16'h01FF);
    chk("R1 reset mode", int'(wm), 0);
    chk("R1 reset busy", int'(busy | done), 0);
    tick();
    // R2 page mode push/pull
    repeat (3) do_push();
    repeat (3) do_pull();
    // R3 low byte wraps, page fixed
    do_pull();
    @(negedge clk); chk("R3 wrap up", int'(sp), 16'h0100);
    tick(); do_push();
    @(negedge clk); chk("R3 wrap down", int'(sp), 16'h01FF);
    tick();
    do_tsy();
    // R7 page wrap on second pointer byte
    ind(8'h00, 8'h05);
    ind(8'h80, 8'h22);
    // R10 restart ignored
    disp = 8'h10; start = 1; tick(); start = 0;
    tick(); disp = 8'h44; start = 1; tick(); start = 0;
    repeat (5) tick();
    // R11 simultaneous push and pull
    push = 1; pull = 1; tick(); push = 0; pull = 0;
    @(negedge clk); chk("R11 hold", int'(sp), 16'h01FF);
    // R5 transfer beats push
    y = 8'h01; tys = 1; push = 1; tick(); tys = 0; push = 0;
    @(negedge clk); chk("R5 word sp", int'(sp), 16'h01FF);
    chk("R5 word mode", int'(wm), 1);
    tick();
    // R8 word carry
    ind(8'h00, 8'h03);
    do_pull();
    @(negedge clk); chk("R2 word carry up", int'(sp), 16'h0200);
    tick(); do_push();
    // build 0x0300 word
    do_tsy(); do_pull(); do_tys(8'h03);
    @(negedge clk); chk("R5 sp 0300", int'(sp), 16'h0300);
    tick();
    // R9 ea wrap
    ind(8'h00, 8'h10);
    chk("R9 ea wrap", int'(ea), 16'h000F);
    // R6 zero extension
    ind(8'hF0, 8'h01);
    do_push();
    @(negedge clk); chk("R2 word borrow", int'(sp), 16'h02FF);
    tick();
    tys = 1; tsy = 1; y = 8'h07; tick(); tys = 0; tsy = 0;
    @(negedge clk); chk("R5 tys wins", int'(wm), 1);
    repeat (2) tick();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule